// File: doc/BRIEF.md
# DTMF Steering Guard-Time Controller

This block sits behind a dual-tone frequency detector. The detector supplies a tone-present flag and the row and column indices of the detected pair. The controller applies two digital guard timers in place of an external RC steering network. The first timer checks that a tone has lasted long enough before it is registered. The second checks that the pause after a registered tone is long enough before a new one is accepted. As a result, short bursts are rejected and short dropouts are bridged.

A tone that qualifies is converted into a 4-bit character code and held in an output latch. A delayed-steering flag reports the registration. An inhibit input blocks the four letter keys. An output-enable input qualifies the data bus in place of a three-state driver. A power-down input halts the timers and the steering logic.

Both guard times are programmable, counted in clock cycles, and set independently of each other.

Top module: `dtmf_steer_ctrl`

## Requirements
- R1: While the controller is released, the pair on `row_i`/`col_i` is latched at the clock edge that ends the P-th consecutive cycle of `est_i` high, where P is `present_cnt_i`. The pair is sampled at that edge.
- R2: A burst of `est_i` high lasting fewer than P cycles leaves the latched code and `std_o` unchanged, and leaves the controller released.
- R3: `std_o` rises one clock cycle after the edge that latches the code, so the data is valid one cycle before the flag.
- R4: After a latch, the controller is released at the edge that ends the A-th consecutive cycle of `est_i` low, where A is `absent_cnt_i`. `std_o` falls one cycle after that edge. A dropout of fewer than A cycles keeps `std_o` high and the code latched.
- R5: Only one latch occurs per held period. While held, `est_i` high never latches a new pair, and the code does not change while `std_o` is high.
- R6: Rows 0..3 and columns 0..3 index the keypad grid `1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D`. The codes are: digits 1..9 map to 1..9, 0 to 10, * to 11, # to 12, A to 13, B to 14, C to 15 and D to 0.
- R7: While `inhibit_i` is high, a pair in column 3 (A, B, C or D) is never qualified. The previous code remains on the latch.
- R8: With `oe_i` low, `code_vld_o` is 0 and `code_o` is 0000. With `oe_i` high, `code_vld_o` is 1 and `code_o` shows the latched code.
- R9: While `pdwn_i` is high, both timers are cleared and the controller is forced released. `std_o` is 0 from the next edge. The latched code is kept.
- R10: A guard count of 0 behaves as a count of 1.
- R11: After reset, the latched code is 0000, `std_o` is 0 and the controller is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdwn_i | input | 1 | Power-down |
| inhibit_i | input | 1 | Block letter keys A-D |
| oe_i | input | 1 | Data output enable |
| est_i | input | 1 | Early-steering flag from the detector |
| row_i | input | 2 | Low-group (row) index |
| col_i | input | 2 | High-group (column) index |
| present_cnt_i | input | CNT_W | Tone-present guard time, in cycles |
| absent_cnt_i | input | CNT_W | Tone-absent guard time, in cycles |
| code_o | output | 4 | Latched character code, forced to 0 when disabled |
| code_vld_o | output | 1 | Data-bus valid (stands in for three-state drive) |
| std_o | output | 1 | Delayed steering flag |

## Verification
The hardest situation to create from the ports is a burst or a dropout that lands exactly on a guard boundary, one cycle short or exactly long enough. It matters most when that boundary follows a held period that a short dropout has extended. To reach it, the stimulus draws burst and gap lengths at random in a narrow band around the two programmed counts, which are re-drawn between phases. Directed sequences add the exact P-1/P and A-1/A edges, a zero count, inhibited letter keys and power-down during a held tone.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  typedef enum logic {ST_FREE = 1'b0, ST_HELD = 1'b1} steer_st_e;

  // keypad grid: rows 697..941 Hz, columns 1209..1633 Hz
  function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] c;
    if (col == 2'd3)      c = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
    else if (row != 2'd3) c = 4'd1 + 4'd3 * {2'b00, row} + {2'b00, col};
    else begin
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        default: c = 4'd12;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/dtmf_key_enc.sv
module dtmf_key_enc (
  input  logic [1:0] row_i,
  input  logic [1:0] col_i,
  input  logic       inhibit_i,
  output logic [3:0] code_o,
  output logic       allow_o
);
  always_comb begin
    code_o  = dtmf_pkg::key_code(row_i, col_i);
    allow_o = !(inhibit_i && col_i == 2'd3);
  end
endmodule

// File: rtl/dtmf_guard_cnt.sv
module dtmf_guard_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  localparam int NW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [NW-1:0]    nxt, lim;

  always_comb begin
    nxt    = {1'b0, cnt_q} + NW'(1);
    lim    = (limit_i == '0) ? NW'(1) : {1'b0, limit_i};
    done_o = run_i && !clr_i && (nxt >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || !run_i || done_o) cnt_q <= '0;
    else                               cnt_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pdwn_i,
  input  logic             inhibit_i,
  input  logic             oe_i,
  input  logic             est_i,
  input  logic [1:0]       row_i,
  input  logic [1:0]       col_i,
  input  logic [CNT_W-1:0] present_cnt_i,
  input  logic [CNT_W-1:0] absent_cnt_i,
  output logic [3:0]       code_o,
  output logic             code_vld_o,
  output logic             std_o
);
  import dtmf_pkg::*;

  steer_st_e  st_q;
  logic [3:0] code_q, enc_code;
  logic       allow, p_done, a_done, std_q;

  dtmf_key_enc u_enc (
    .row_i(row_i), .col_i(col_i), .inhibit_i(inhibit_i),
    .code_o(enc_code), .allow_o(allow)
  );

  dtmf_guard_cnt #(.CNT_W(CNT_W)) u_present (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pdwn_i),
    .run_i(st_q == ST_FREE && est_i && allow),
    .limit_i(present_cnt_i), .done_o(p_done)
  );

  dtmf_guard_cnt #(.CNT_W(CNT_W)) u_absent (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pdwn_i),
    .run_i(st_q == ST_HELD && !est_i),
    .limit_i(absent_cnt_i), .done_o(a_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FREE;
      code_q <= 4'd0;
    end else if (pdwn_i) begin
      st_q   <= ST_FREE;
    end else if (st_q == ST_FREE && p_done) begin
      st_q   <= ST_HELD;
      code_q <= enc_code;
    end else if (st_q == ST_HELD && a_done) begin
      st_q   <= ST_FREE;
    end
  end

  // flag trails the latch by one cycle: data set-up before steering
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) std_q <= 1'b0;
    else         std_q <= !pdwn_i && (st_q == ST_HELD);
  end

  assign std_o      = std_q;
  assign code_vld_o = oe_i;
  assign code_o     = oe_i ? code_q : 4'd0;
endmodule

// File: rtl/dtmf_steer_ctrl_chk.sv
module dtmf_steer_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pdwn_i,
  input logic       inhibit_i,
  input logic       est_i,
  input logic [1:0] col_i,
  input logic       held,
  input logic [3:0] code_q,
  input logic [3:0] code_o,
  input logic       code_vld_o,
  input logic       std_o
);
  // R3
  std_after_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(held) && !pdwn_i) |=> std_o);
  // R5
  no_relatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && est_i && !pdwn_i) |=> held);
  // R5
  code_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    std_o |-> $stable(code_q));
  // R7
  inhibit_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held && inhibit_i && col_i == 2'd3) |=> !held);
  // R8
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_vld_o |-> code_o == 4'd0);
  // R9
  pdwn_std_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pdwn_i) |-> !std_o);
endmodule

bind dtmf_steer_ctrl dtmf_steer_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pdwn_i(pdwn_i), .inhibit_i(inhibit_i),
  .est_i(est_i), .col_i(col_i), .held(st_q == dtmf_pkg::ST_HELD),
  .code_q(code_q), .code_o(code_o), .code_vld_o(code_vld_o), .std_o(std_o)
);

// File: tb/dtmf_steer_ctrl_tb_top.sv
`timescale 1ns/1ps
module dtmf_steer_ctrl_tb_top;
  localparam int CW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pdwn_i = 0, inhibit_i = 0, oe_i = 1, est_i = 0;
  logic [1:0] row_i = 0, col_i = 0;
  logic [CW-1:0] present_cnt_i = 4, absent_cnt_i = 3;
  logic [3:0] code_o;
  logic code_vld_o, std_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [3:0] exp_code = 0;
  bit held = 0;

  always #2 clk_i = ~clk_i;

  dtmf_steer_ctrl #(.CNT_W(CW)) dut_i (.*);

  function automatic logic [3:0] ref_code(input int r, input int c);
    case ({r[1:0], c[1:0]})
      4'h0: return 4'd1;  4'h1: return 4'd2;  4'h2: return 4'd3;  4'h3: return 4'd13;
      4'h4: return 4'd4;  4'h5: return 4'd5;  4'h6: return 4'd6;  4'h7: return 4'd14;
      4'h8: return 4'd7;  4'h9: return 4'd8;  4'hA: return 4'd9;  4'hB: return 4'd15;
      4'hC: return 4'd11; 4'hD: return 4'd10; 4'hE: return 4'd12; default: return 4'd0;
    endcase
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // est high for len cycles; check code at the end (R1/R2/R5/R6/R7)
  task automatic burst(input int r, input int c, input int len, input string req);
    row_i = r[1:0]; col_i = c[1:0]; est_i = 1;
    repeat (len) tick();
    est_i = 0;
    if (!held && len >= eff(present_cnt_i) && !(inhibit_i && c == 3)) begin
      exp_code = ref_code(r, c);
      held = 1;
    end
    chk(code_o == exp_code, req, code_o, exp_code);
  endtask

  // est low for len (>=1) cycles; std checked after the first (R3/R4)
  task automatic gap(input int len, input string req);
    est_i = 0;
    tick();
    chk(std_o == held, req, std_o, held);
    repeat (len - 1) tick();
    if (held && len >= eff(absent_cnt_i)) held = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #3000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1; tick();
    // R11 reset state
    chk(code_o == 0 && std_o == 0, "R11", {code_o, std_o}, 0);

    // R1 exact P latches; R3 std one cycle later
    present_cnt_i = 4; absent_cnt_i = 3;
    row_i = 1; col_i = 1; est_i = 1;
    repeat (3) tick();
    chk(code_o == 0, "R2 P-1 cycles", code_o, 0);
    tick();
    chk(code_o == 5 && std_o == 0, "R1 latch at P", {code_o, std_o}, 8'h0A);
    tick();
    chk(std_o == 1, "R3 std after latch", std_o, 1);
    exp_code = 5; held = 1;
    // R5 long hold does not relatch even when pair changes
    row_i = 0; col_i = 0; repeat (10) tick();
    chk(code_o == 5, "R5 no relatch", code_o, 5);
    // R4 dropout A-1 bridged, then exact A release
    est_i = 0; repeat (2) tick(); est_i = 1; tick();
    chk(std_o == 1 && code_o == 5, "R4 short dropout", std_o, 1);
    est_i = 0; repeat (3) tick();
    chk(std_o == 1, "R4 std at A edge", std_o, 1);
    tick();
    chk(std_o == 0, "R4 std falls", std_o, 0);
    held = 0;

    // R2 short burst
    burst(2, 2, 3, "R2 short burst"); gap(4, "R2 std stays low");
    // R6 all keys
    for (int k = 0; k < 16; k++) begin
      burst(k / 4, k % 4, 4, "R6 key code"); gap(3, "R3 std high");
    end
    // R7 inhibit letters
    inhibit_i = 1;
    burst(1, 3, 8, "R7 letter inhibited"); gap(3, "R7 std low");
    burst(3, 2, 4, "R7 digit passes"); gap(3, "R7 std");
    inhibit_i = 0;
    // R8 output enable
    oe_i = 0; tick();
    chk(code_o == 0 && code_vld_o == 0, "R8 disabled", {code_o, code_vld_o}, 0);
    oe_i = 1; tick();
    chk(code_o == exp_code && code_vld_o == 1, "R8 enabled", code_o, exp_code);
    // R9 power-down while held
    burst(0, 1, 5, "R9 setup");
    est_i = 1; pdwn_i = 1; tick(); tick();
    chk(std_o == 0 && code_o == exp_code, "R9 pdwn", {std_o, code_o}, {1'b0, exp_code});
    est_i = 0; pdwn_i = 0; held = 0; tick();
    burst(2, 0, 4, "R9 free after pdwn"); gap(3, "R9 std");
    // R10 zero counts
    present_cnt_i = 0; absent_cnt_i = 0;
    burst(0, 2, 1, "R10 zero present"); gap(1, "R10 zero absent");
    burst(2, 1, 1, "R10 relatch"); gap(2, "R10 std");

    // random bursts around the guard boundaries
    for (int ph = 0; ph < 12; ph++) begin
      present_cnt_i = 2 + $urandom_range(0, 10);
      absent_cnt_i  = 2 + $urandom_range(0, 10);
      gap(absent_cnt_i + 1, "R4 phase settle");
      for (int i = 0; i < 60; i++) begin
        inhibit_i = ($urandom_range(0, 3) == 0);
        burst($urandom_range(0, 3), $urandom_range(0, 3),
              1 + $urandom_range(0, 2 * present_cnt_i), "R1 random burst");
        gap(1 + $urandom_range(0, 2 * absent_cnt_i), "R4 random gap");
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule